// File: doc/BRIEF.md
# Jacobian Point-Doubling Sequencer

This block doubles an elliptic-curve point held in Jacobian projective coordinates (X, Y, Z) on the curve y² = x³ + 7 over a 256-bit prime field. It computes X3 = (3X²)² − 8XY², Y3 = 3X²·(4XY² − X3) − 8Y⁴ and Z3 = 2YZ. The point stays projective throughout, so the block never needs a field inversion. Small constant factors (2, 3, 4, 8) are built from chains of modular additions.

The field multipliers and squarers sit outside the block. The sequencer drives three multiplier lanes and four squarer lanes through go/done handshakes, and each lane has its own operand ports. Inside the block are a capture register file, nine modular adders and three modular subtractors, each of which finishes in one cycle. The work is split into seven dependent levels. Operations within a level run side by side, and the add chains are hidden under the multiply that shares their level. With 257-cycle lanes a doubling takes 257+257+257+1+1+257+1 = 1031 cycles.

A caller places a point on the inputs and pulses `start`. The caller then waits for the one-cycle `done` pulse, and at that pulse the result appears on the outputs.

Top module: `jds_dbl_seq`

## Requirements
- R1: When `done` pulses, `out_x` equals (3X²)² − 2·(4XY²) mod p, where p = 2^256 − 2^32 − 977. The inputs X, Y and Z must each be below p, and the output is fully reduced.
- R2: When `done` pulses, `out_y` equals 3X²·(4XY² − X3) − 8Y⁴ mod p, fully reduced.
- R3: When `done` pulses, `out_z` equals 2·Y·Z mod p, fully reduced.
- R4: Suppose every lane reports done 256 cycles after the cycle in which its go was high. Then `done` is high for exactly one cycle, 1031 cycles after the cycle in which an accepted `start` was high.
- R5: `in_x`, `in_y` and `in_z` are used only in the cycle in which `start` is accepted. Later changes to them have no effect on the result.
- R6: A `start` that arrives while a doubling is in progress is ignored. It changes neither the lane go pattern, nor the `done` timing, nor the result.
- R7: A level ends only after every lane started in that level has reported done. A lane that is k cycles late delays everything after it by exactly k cycles.
- R8: Each lane gets exactly one single-cycle go per doubling, at fixed offsets from the start cycle s when lanes take 257 cycles. Squarer 0 (operand X), squarer 1 (operand Y) and multiplier 0 (Y, Z) go at s. Squarer 2 (Y²) and multiplier 1 (X, Y²) go at s+257. Squarer 3 (3X²) goes at s+514. Multiplier 2 (3X², 4XY² − X3) goes at s+773. No lane gets a go while it is still busy.
- R9: After reset, `done`, all go lines and all outputs are zero. The outputs change only in the cycle in which `done` goes high, and they hold their value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a doubling; accepted only when idle |
| in_x | input | 256 | X coordinate of P |
| in_y | input | 256 | Y coordinate of P |
| in_z | input | 256 | Z coordinate of P |
| done | output | 1 | One-cycle completion pulse |
| out_x | output | 256 | X coordinate of 2P |
| out_y | output | 256 | Y coordinate of 2P |
| out_z | output | 256 | Z coordinate of 2P |
| mul_go | output | 3 | Go strobe per multiplier lane |
| mul_a | output | 3×256 | First operand per multiplier lane |
| mul_b | output | 3×256 | Second operand per multiplier lane |
| mul_done | input | 3 | Done strobe per multiplier lane |
| mul_res | input | 3×256 | Product per multiplier lane, valid with done |
| sqr_go | output | 4 | Go strobe per squarer lane |
| sqr_a | output | 4×256 | Operand per squarer lane |
| sqr_done | input | 4 | Done strobe per squarer lane |
| sqr_res | input | 4×256 | Square per squarer lane, valid with done |

## Verification
Most faults in the level state or the pending masks show up on the lane go lines within one cycle of the level boundary. They appear either as a go at the wrong offset, as a repeated go, or as a missing go, and `done` then moves away from cycle 1031. A wrong capture strobe or wrong operand routing is silent until the result emerges, up to about 1000 cycles later. It then shows as a wrong coordinate, which is why each coordinate is checked on its own against a big-integer model over inputs that include zero, one and p − 1. Lanes are made deliberately late in single levels so that an early level advance becomes a timing error on the go lines.

// File: rtl/jds_pkg.sv
package jds_pkg;

  localparam int unsigned FW = 256;
  localparam logic [FW-1:0] FIELD_P =
    256'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_FFFFFC2F;

  localparam int unsigned N_MUL = 3;
  localparam int unsigned N_SQR = 4;
  localparam int unsigned N_ADD = 9;
  localparam int unsigned N_SUB = 3;

  typedef enum logic [2:0] {
    LV_IDLE = 3'd0,
    LV_1    = 3'd1,
    LV_2    = 3'd2,
    LV_3    = 3'd3,
    LV_4    = 3'd4,
    LV_5    = 3'd5,
    LV_6    = 3'd6,
    LV_7    = 3'd7
  } lvl_e;

endpackage

// File: rtl/jds_modaddsub.sv
module jds_modaddsub #(
  parameter int unsigned   W   = 256,
  parameter logic [W-1:0]  P   = '1,
  parameter bit            SUB = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r
);

  generate
    if (SUB) begin : g_sub
      logic [W:0] diff;
      always_comb begin
        diff = {1'b0, a} - {1'b0, b};
        // a borrow means a < b: fold back into range by adding the modulus
        if (diff[W]) r = diff[W-1:0] + P;
        else         r = diff[W-1:0];
      end
    end else begin : g_add
      logic [W:0] sum;
      logic [W:0] red;
      always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        red = sum - {1'b0, P};
        // no borrow on the second adder means sum >= P
        if (red[W]) r = sum[W-1:0];
        else        r = red[W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/jds_ctrl.sv
module jds_ctrl
  import jds_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N_MUL-1:0] mul_done,
  input  logic [N_SQR-1:0] sqr_done,
  output logic [N_MUL-1:0] mul_go,
  output logic [N_SQR-1:0] sqr_go,
  output logic [N_MUL-1:0] mul_cap,
  output logic [N_SQR-1:0] sqr_cap,
  output logic [N_ADD-1:0] add_en,
  output logic [N_SUB-1:0] sub_en,
  output logic             x_load,
  output logic             out_load,
  output logic             done
);

  lvl_e             lvl_q, lvl_d;
  logic [1:0]       step_q, step_d;
  logic [N_MUL-1:0] mpend_q, mpend_d;
  logic [N_SQR-1:0] spend_q, spend_d;
  logic             done_q;
  logic             accept;
  logic             lvl_end;
  logic [1:0]       chain_last;
  logic             s0, s1, s2;

  assign s0 = (step_q == 2'd0);
  assign s1 = (step_q == 2'd1);
  assign s2 = (step_q == 2'd2);

  assign accept = (lvl_q == LV_IDLE) && start;

  // lane issue: every lane is dedicated to one operation of one level
  always_comb begin
    mul_go    = '0;
    sqr_go    = '0;
    mul_go[0] = accept;
    sqr_go[0] = accept;
    sqr_go[1] = accept;
    mul_go[1] = (lvl_q == LV_2) && s0;
    sqr_go[2] = (lvl_q == LV_2) && s0;
    sqr_go[3] = (lvl_q == LV_3) && s0;
    mul_go[2] = (lvl_q == LV_6) && s0;
  end

  assign mul_cap = mul_done & mpend_q;
  assign sqr_cap = sqr_done & spend_q;
  assign mpend_d = (mpend_q & ~mul_done) | mul_go;
  assign spend_d = (spend_q & ~sqr_done) | sqr_go;

  // add chains hidden under the multiply of their level
  always_comb begin
    add_en    = '0;
    add_en[0] = (lvl_q == LV_2) && s0;   // 2*X^2
    add_en[2] = (lvl_q == LV_2) && s0;   // 2*YZ
    add_en[1] = (lvl_q == LV_2) && s1;   // 3*X^2
    add_en[3] = (lvl_q == LV_3) && s0;   // 2*XY^2
    add_en[6] = (lvl_q == LV_3) && s0;   // 2*Y^4
    add_en[4] = (lvl_q == LV_3) && s1;   // 4*XY^2
    add_en[7] = (lvl_q == LV_3) && s1;   // 4*Y^4
    add_en[5] = (lvl_q == LV_3) && s2;   // 8*XY^2
    add_en[8] = (lvl_q == LV_3) && s2;   // 8*Y^4
  end

  always_comb begin
    sub_en    = '0;
    sub_en[0] = (lvl_q == LV_4);
    sub_en[1] = (lvl_q == LV_5);
    sub_en[2] = (lvl_q == LV_7);
  end

  assign x_load   = accept;
  assign out_load = (lvl_q == LV_7);

  always_comb begin
    case (lvl_q)
      LV_2:    chain_last = 2'd1;
      LV_3:    chain_last = 2'd2;
      default: chain_last = 2'd0;
    endcase
  end

  assign lvl_end = (lvl_q != LV_IDLE) && (mpend_d == '0) && (spend_d == '0)
                   && (step_q >= chain_last);

  always_comb begin
    lvl_d = lvl_q;
    case (lvl_q)
      LV_IDLE: if (accept)  lvl_d = LV_1;
      LV_1:    if (lvl_end) lvl_d = LV_2;
      LV_2:    if (lvl_end) lvl_d = LV_3;
      LV_3:    if (lvl_end) lvl_d = LV_4;
      LV_4:    if (lvl_end) lvl_d = LV_5;
      LV_5:    if (lvl_end) lvl_d = LV_6;
      LV_6:    if (lvl_end) lvl_d = LV_7;
      LV_7:    if (lvl_end) lvl_d = LV_IDLE;
      default: lvl_d = LV_IDLE;
    endcase
  end

  always_comb begin
    if (lvl_d != lvl_q)        step_d = 2'd0;
    else if (step_q != 2'd3)   step_d = step_q + 2'd1;
    else                       step_d = step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= LV_IDLE;
      step_q  <= 2'd0;
      mpend_q <= '0;
      spend_q <= '0;
      done_q  <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      step_q  <= step_d;
      mpend_q <= mpend_d;
      spend_q <= spend_d;
      done_q  <= out_load;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/jds_regfile.sv
module jds_regfile
  import jds_pkg::*;
#(
  parameter int unsigned  W = 256,
  parameter logic [W-1:0] P = FIELD_P
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [W-1:0]             in_x,
  input  logic [W-1:0]             in_y,
  input  logic [W-1:0]             in_z,
  input  logic                     x_load,
  input  logic [N_MUL-1:0]         mul_cap,
  input  logic [N_SQR-1:0]         sqr_cap,
  input  logic [N_MUL-1:0][W-1:0]  mul_res,
  input  logic [N_SQR-1:0][W-1:0]  sqr_res,
  input  logic [N_ADD-1:0]         add_en,
  input  logic [N_SUB-1:0]         sub_en,
  input  logic                     out_load,
  output logic [N_MUL-1:0][W-1:0]  mul_a,
  output logic [N_MUL-1:0][W-1:0]  mul_b,
  output logic [N_SQR-1:0][W-1:0]  sqr_a,
  output logic [W-1:0]             out_x,
  output logic [W-1:0]             out_y,
  output logic [W-1:0]             out_z
);

  logic [W-1:0] x_q;
  logic [W-1:0] sq_q [N_SQR];
  logic [W-1:0] mu_q [N_MUL];
  logic [W-1:0] ad_q [N_ADD];
  logic [W-1:0] ad_a [N_ADD];
  logic [W-1:0] ad_r [N_ADD];
  logic [W-1:0] sb_q [N_SUB-1];
  logic [W-1:0] sb_a [N_SUB];
  logic [W-1:0] sb_b [N_SUB];
  logic [W-1:0] sb_r [N_SUB];

  // lane operands: level 1 lanes take the inputs straight from the ports
  assign sqr_a[0] = in_x;
  assign sqr_a[1] = in_y;
  assign sqr_a[2] = sq_q[1];
  assign sqr_a[3] = ad_q[1];
  assign mul_a[0] = in_y;
  assign mul_b[0] = in_z;
  assign mul_a[1] = x_q;
  assign mul_b[1] = sq_q[1];
  assign mul_a[2] = ad_q[1];
  assign mul_b[2] = sb_q[1];

  // every adder doubles or adds a captured value: constants by addition
  assign ad_a[0] = sq_q[0];
  assign ad_a[1] = ad_q[0];
  assign ad_a[2] = mu_q[0];
  assign ad_a[3] = mu_q[1];
  assign ad_a[4] = ad_q[3];
  assign ad_a[5] = ad_q[4];
  assign ad_a[6] = sq_q[2];
  assign ad_a[7] = ad_q[6];
  assign ad_a[8] = ad_q[7];

  generate
    for (genvar i = 0; i < N_ADD; i++) begin : g_add
      logic [W-1:0] b_opd;
      if (i == 1) begin : g_tri
        assign b_opd = sq_q[0];
      end else begin : g_dbl
        assign b_opd = ad_a[i];
      end
      jds_modaddsub #(.W(W), .P(P), .SUB(1'b0)) i_add (
        .a (ad_a[i]),
        .b (b_opd),
        .r (ad_r[i])
      );
    end
  endgenerate

  assign sb_a[0] = sq_q[3];   // M^2
  assign sb_b[0] = ad_q[5];   // 2S
  assign sb_a[1] = ad_q[4];   // S
  assign sb_b[1] = sb_q[0];   // X3
  assign sb_a[2] = mu_q[2];   // M*(S-X3)
  assign sb_b[2] = ad_q[8];   // 8Y^4

  generate
    for (genvar j = 0; j < N_SUB; j++) begin : g_sub
      jds_modaddsub #(.W(W), .P(P), .SUB(1'b1)) i_sub (
        .a (sb_a[j]),
        .b (sb_b[j]),
        .r (sb_r[j])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (x_load) x_q <= in_x;
    for (int i = 0; i < N_SQR; i++) begin
      if (sqr_cap[i]) sq_q[i] <= sqr_res[i];
    end
    for (int i = 0; i < N_MUL; i++) begin
      if (mul_cap[i]) mu_q[i] <= mul_res[i];
    end
    for (int i = 0; i < N_ADD; i++) begin
      if (add_en[i]) ad_q[i] <= ad_r[i];
    end
    for (int i = 0; i < N_SUB - 1; i++) begin
      if (sub_en[i]) sb_q[i] <= sb_r[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_x <= '0;
      out_y <= '0;
      out_z <= '0;
    end else if (out_load) begin
      out_x <= sb_q[0];
      out_y <= sb_r[N_SUB-1];
      out_z <= ad_q[2];
    end
  end

  logic unused_en;
  assign unused_en = sub_en[N_SUB-1];

endmodule

// File: rtl/jds_dbl_seq.sv
module jds_dbl_seq
  import jds_pkg::*;
#(
  parameter int unsigned  W = FW,
  parameter logic [W-1:0] P = FIELD_P
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [W-1:0]            in_x,
  input  logic [W-1:0]            in_y,
  input  logic [W-1:0]            in_z,
  output logic                    done,
  output logic [W-1:0]            out_x,
  output logic [W-1:0]            out_y,
  output logic [W-1:0]            out_z,
  output logic [N_MUL-1:0]        mul_go,
  output logic [N_MUL-1:0][W-1:0] mul_a,
  output logic [N_MUL-1:0][W-1:0] mul_b,
  input  logic [N_MUL-1:0]        mul_done,
  input  logic [N_MUL-1:0][W-1:0] mul_res,
  output logic [N_SQR-1:0]        sqr_go,
  output logic [N_SQR-1:0][W-1:0] sqr_a,
  input  logic [N_SQR-1:0]        sqr_done,
  input  logic [N_SQR-1:0][W-1:0] sqr_res
);

  logic [1:0]       rs_q;
  logic             core_rst_n;
  logic [N_MUL-1:0] mul_cap;
  logic [N_SQR-1:0] sqr_cap;
  logic [N_ADD-1:0] add_en;
  logic [N_SUB-1:0] sub_en;
  logic             x_load;
  logic             out_load;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  jds_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .start    (start),
    .mul_done (mul_done),
    .sqr_done (sqr_done),
    .mul_go   (mul_go),
    .sqr_go   (sqr_go),
    .mul_cap  (mul_cap),
    .sqr_cap  (sqr_cap),
    .add_en   (add_en),
    .sub_en   (sub_en),
    .x_load   (x_load),
    .out_load (out_load),
    .done     (done)
  );

  jds_regfile #(.W(W), .P(P)) i_rf (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .in_x     (in_x),
    .in_y     (in_y),
    .in_z     (in_z),
    .x_load   (x_load),
    .mul_cap  (mul_cap),
    .sqr_cap  (sqr_cap),
    .mul_res  (mul_res),
    .sqr_res  (sqr_res),
    .add_en   (add_en),
    .sub_en   (sub_en),
    .out_load (out_load),
    .mul_a    (mul_a),
    .mul_b    (mul_b),
    .sqr_a    (sqr_a),
    .out_x    (out_x),
    .out_y    (out_y),
    .out_z    (out_z)
  );

endmodule

// File: rtl/jds_dbl_seq_chk.sv
module jds_dbl_seq_chk
  import jds_pkg::*;
#(
  parameter int unsigned W = FW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic [W-1:0]     out_x,
  input logic [W-1:0]     out_y,
  input logic [W-1:0]     out_z,
  input logic [N_MUL-1:0] mul_go,
  input logic [N_MUL-1:0] mul_done,
  input logic [N_SQR-1:0] sqr_go,
  input logic [N_SQR-1:0] sqr_done
);

  localparam int unsigned NL = N_MUL + N_SQR;

  logic [NL-1:0] go_all, dn_all;
  logic [NL-1:0] ubusy_q;
  logic          busy_q;
  logic          idle;
  logic          acc;
  logic [3:0]    ev_q, ev_d;

  assign go_all = {sqr_go, mul_go};
  assign dn_all = {sqr_done, mul_done};
  assign idle   = !busy_q || done;
  assign acc    = idle && start;

  always_comb begin
    ev_d = acc ? 4'd0 : ev_q;
    for (int i = 0; i < NL; i++) begin
      if (dn_all[i] && ubusy_q[i]) ev_d = ev_d + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ubusy_q <= '0;
      ev_q    <= 4'd0;
    end else begin
      busy_q  <= acc ? 1'b1 : (done ? 1'b0 : busy_q);
      ubusy_q <= (ubusy_q & ~dn_all) | go_all;
      ev_q    <= ev_d;
    end
  end

  p_single_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(out_x) && $stable(out_y) && $stable(out_z)));

  p_first_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ubusy_q == '0) |-> (mul_go[0] && sqr_go[0] && sqr_go[1]));

  p_quiet_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start) |-> (go_all == '0));

  p_no_reissue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|go_all) |-> ((go_all & ubusy_q) == '0));

  p_all_lanes_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ev_q == 4'(NL)));

endmodule

bind jds_dbl_seq jds_dbl_seq_chk #(.W(W)) i_chk (.*);

// File: tb/test_jds_dbl_seq.sv
`timescale 1ns/1ps
module test_jds_dbl_seq;
  import jds_pkg::*;

  localparam int unsigned W    = 256;
  localparam int          MLAT = 257;
  localparam logic [W-1:0] P   = FIELD_P;
  localparam int          NL   = 7;

  logic clk;
  logic rst_n;
  logic start;
  logic [W-1:0] in_x, in_y, in_z;
  logic done;
  logic [W-1:0] out_x, out_y, out_z;
  logic [2:0] mul_go, mul_done;
  logic [2:0][W-1:0] mul_a, mul_b, mul_res;
  logic [3:0] sqr_go, sqr_done;
  logic [3:0][W-1:0] sqr_a, sqr_res;

  jds_dbl_seq i_jds_dbl_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_x(in_x), .in_y(in_y), .in_z(in_z),
    .done(done), .out_x(out_x), .out_y(out_y), .out_z(out_z),
    .mul_go(mul_go), .mul_a(mul_a), .mul_b(mul_b),
    .mul_done(mul_done), .mul_res(mul_res),
    .sqr_go(sqr_go), .sqr_a(sqr_a),
    .sqr_done(sqr_done), .sqr_res(sqr_res)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit ready = 1'b0;
  string run_tag = "";

  task automatic chk(input bit ok, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mulm(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] t;
    t = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    t = t % {{W{1'b0}}, P};
    return t[W-1:0];
  endfunction

  function automatic logic [W-1:0] subm(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W+1:0] t;
    t = {2'b0, a} + {2'b0, P} - {2'b0, b};
    if (t >= {2'b0, P}) t = t - {2'b0, P};
    return t[W-1:0];
  endfunction

  // lane models: index 0..2 multipliers, 3..6 squarers
  int           u_rem [NL];
  int           u_ex  [NL];
  logic [W-1:0] u_res [NL];
  logic [NL-1:0] go7;
  logic [W-1:0] opa [NL];
  logic [W-1:0] opb [NL];

  always_comb begin
    go7 = {sqr_go, mul_go};
    for (int i = 0; i < 3; i++) begin
      opa[i] = mul_a[i];
      opb[i] = mul_b[i];
    end
    for (int i = 0; i < 4; i++) begin
      opa[3+i] = sqr_a[i];
      opb[3+i] = sqr_a[i];
    end
    for (int i = 0; i < 3; i++) begin
      mul_done[i] = (u_rem[i] == 1);
      mul_res[i]  = u_res[i];
    end
    for (int i = 0; i < 4; i++) begin
      sqr_done[i] = (u_rem[3+i] == 1);
      sqr_res[i]  = u_res[3+i];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < NL; i++) begin
      if (!rst_n) begin
        u_rem[i] <= 0;
        u_res[i] <= '0;
      end else if (go7[i]) begin
        u_rem[i] <= MLAT - 1 + u_ex[i];
        u_res[i] <= mulm(opa[i], opb[i]);
      end else if (u_rem[i] > 0) begin
        u_rem[i] <= u_rem[i] - 1;
      end
    end
  end

  // reference model: schedule and results, compared every cycle
  bit           m_busy = 1'b0;
  int           m_s0, g2, g3, g6, tdone;
  logic [W-1:0] ex_x, ex_y, ex_z;
  logic [W-1:0] hold_x = '0, hold_y = '0, hold_z = '0;

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  always @(negedge clk) begin
    if (ready) begin
      logic [NL-1:0] eg;
      logic          ed;
      int            rel;
      if (!m_busy && start) begin
        logic [W-1:0] x2, y2, m, s, t;
        int l2, l3;
        m_busy = 1'b1;
        m_s0 = cyc;
        x2 = mulm(in_x, in_x);
        y2 = mulm(in_y, in_y);
        m  = mulm(256'd3, x2);
        s  = mulm(256'd4, mulm(in_x, y2));
        t  = mulm(256'd8, mulm(y2, y2));
        ex_x = subm(mulm(m, m), mulm(256'd2, s));
        ex_y = subm(mulm(m, subm(s, ex_x)), t);
        ex_z = mulm(256'd2, mulm(in_y, in_z));
        g2 = MLAT + maxi(u_ex[0], maxi(u_ex[3], u_ex[4]));
        l2 = maxi(MLAT + maxi(u_ex[1], u_ex[5]), 2);
        g3 = g2 + l2;
        l3 = maxi(MLAT + u_ex[6], 3);
        g6 = g3 + l3 + 2;
        tdone = g6 + MLAT + u_ex[2] + 1;
      end
      eg = '0;
      ed = 1'b0;
      rel = cyc - m_s0;
      if (m_busy) begin
        eg[0] = (rel == 0);
        eg[3] = (rel == 0);
        eg[4] = (rel == 0);
        eg[1] = (rel == g2);
        eg[5] = (rel == g2);
        eg[6] = (rel == g3);
        eg[2] = (rel == g6);
        ed    = (rel == tdone);
      end
      chk({done, go7} == {ed, eg}, {"R4 R7 R8 schedule ", run_tag},
          W'({done, go7}), W'({ed, eg}));
      if (ed) begin
        hold_x = ex_x;
        hold_y = ex_y;
        hold_z = ex_z;
        m_busy = 1'b0;
        chk(out_x == ex_x, {"R1 out_x ", run_tag}, out_x, ex_x);
        chk(out_y == ex_y, {"R2 out_y ", run_tag}, out_y, ex_y);
        chk(out_z == ex_z, {"R3 out_z ", run_tag}, out_z, ex_z);
      end else begin
        chk(out_x == hold_x && out_y == hold_y && out_z == hold_z,
            {"R9 hold ", run_tag}, out_x ^ out_y ^ out_z, hold_x ^ hold_y ^ hold_z);
      end
    end
  end

  task automatic wait_idle();
    @(posedge clk);
    while (m_busy) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic run(input logic [W-1:0] x, input logic [W-1:0] y,
                     input logic [W-1:0] z, input string tag);
    @(posedge clk); #1;
    run_tag = tag;
    in_x = x; in_y = y; in_z = z;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  localparam logic [W-1:0] GX =
    256'h79BE667E_F9DCBBAC_55A06295_CE870B07_029BFCDB_2DCE28D9_59F2815B_16F81798;
  localparam logic [W-1:0] GY =
    256'h483ADA77_26A3C465_5DA4FBFC_0E1108A8_FD17B448_A6855419_9C47D08F_FB10D4B8;

  initial begin
    start = 1'b0;
    in_x = '0; in_y = '0; in_z = '0;
    for (int i = 0; i < NL; i++) u_ex[i] = 0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0 && go7 == '0, "R9 reset done/go", W'({done, go7}), '0);
    chk(out_x == '0 && out_y == '0 && out_z == '0, "R9 reset outputs",
        out_x | out_y | out_z, '0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1 ready = 1'b1;

    run(GX, GY, 256'd1, "generator");
    wait_idle();
    run(256'd1, 256'd2, 256'd1, "small");
    wait_idle();
    run(P - 1, P - 1, P - 1, "p-1");
    wait_idle();
    run(GX, 256'd0, 256'd5, "y zero");
    wait_idle();

    // R5: inputs scrambled right after the accepted start
    run(256'h1234_5678_9ABC_DEF0, GX, GY, "R5 late inputs");
    in_x = GY; in_y = 256'd7; in_z = P - 2;
    wait_idle();

    // R6: second start while busy carries other operands
    run(GY, GX, 256'd3, "R6 busy start");
    repeat (300) @(posedge clk); #1;
    in_x = 256'd9; in_y = 256'd9; in_z = 256'd9;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (400) @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    wait_idle();

    // R7: late lanes in first and later levels
    u_ex[4] = 5;
    run(GX, GY, 256'd11, "R7 late squarer1");
    wait_idle();
    u_ex[4] = 0;
    u_ex[6] = 9;
    u_ex[1] = 300;
    run(GY, GX, GX, "R7 late level2 and level3");
    wait_idle();
    u_ex[6] = 0;
    u_ex[1] = 0;
    u_ex[2] = 4;
    run(P - 1, 256'd1, P - 1, "R7 late level6");
    wait_idle();
    u_ex[2] = 0;

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(4 * 190000);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired (R4) actual=hung expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule